// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise Detection

This block receives asynchronous serial frames. It looks at the line only when a 16x sample-enable tick is high, so one bit period spans sixteen ticks. A frame begins on a falling edge seen after a quiet, high line. The low start bit is then checked at several sample positions. Each data bit and the stop bit are recovered by a two-of-three vote over the three samples nearest the middle of the bit.

Any doubt seen in the sampled waveform raises a noise indication. This covers stray high samples inside the start bit and votes that are not unanimous. The word is still delivered. A start bit that reads fully high at its middle is dropped as a glitch.

The frame carries 8 or 9 data bits, chosen by a select input, least significant bit first. The received word is presented with a one-cycle valid strobe and two status flags. The serial line input is synchronised inside the block. The reset is asserted asynchronously and released synchronously.

Top module: `uart_ovs_rx`

## Requirements
- R1: Every bit lasts 16 sample ticks. The sample counter numbers them 1 to 16 and restarts at the start edge, so that sample 1 is the first tick after the tick that saw the line low.
- R2: A frame starts only when a tick samples the line low and the three ticks just before it all sampled it high. A low line that follows fewer than three high ticks starts nothing.
- R3: A high reading on start-bit sample 3, 5 or 7 sets the noise flag of that frame, and the word is still delivered.
- R4: A high reading on one or two of start-bit samples 8, 9 and 10 sets the noise flag, and the word is still delivered.
- R5: If start-bit samples 8, 9 and 10 all read high, the receiver returns to idle and gives no valid strobe for that attempt.
- R6: A data bit takes the majority value of its samples 8, 9 and 10. If those three samples are not all equal, the noise flag is set.
- R7: Data arrives least significant bit first. When nine_sel is 0 at the start edge, 8 bits are received and rx_data[8] reads 0. When it is 1, 9 bits are received and bit 8 is the last data bit on the line.
- R8: The stop bit is voted like a data bit. A low vote result sets rx_ferr, and the word is still delivered.
- R9: rx_valid is a single-cycle pulse that follows a sample tick. rx_data, rx_noise and rx_ferr are updated together with it and hold until the next strobe. The exception is rx_noise and rx_ferr, which are cleared at the next start edge.
- R10: Frames whose bits are alternately one tick shorter or alternately one tick longer than nominal (about 3 % rate error) are received without error.
- R11: High readings on start-bit samples 1, 2, 4, 6 and 11 to 15 have no effect on the delivered word or the flags.
- R12: After reset, rx_valid, rx_noise and rx_ferr are 0 and rx_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, high when idle |
| nine_sel | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_data | output | 9 | Received word, first bit in bit 0 |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| rx_noise | output | 1 | Noise seen in the delivered frame |
| rx_ferr | output | 1 | Stop bit voted low in the delivered frame |

## Verification
The assertions watch, on every cycle, the properties that hold over time no matter what stimulus arrives. These are the range of the sample counter, entry to the start state only on a tick from idle, the single-cycle valid pulse tied to a tick, outputs that change only at a strobe or a start edge, and a zero top bit in 8-bit frames.

The sample-position rules cannot be seen without a known waveform. These include which start samples raise noise and which are ignored, the majority vote, glitch rejection, the three-high edge condition, the framing error and the tolerance to rate error. The bench scenarios inject deliberate disturbances at chosen tick positions and compare each delivered word and its flags against values worked out from the requirements.

// File: rtl/uart_ovs_pkg.sv
package uart_ovs_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_st_e;
endpackage

// File: rtl/uart_ovs_rstsync.sv
// Reset conditioner: assertion is immediate, release waits two clock edges.
module uart_ovs_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      stage2 <= stage1;
    end
  end

  assign rst_q_n = stage2;
endmodule

// File: rtl/uart_ovs_sync.sv
// Two-flop synchroniser for the serial line; resets to the idle (high) level.
module uart_ovs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta;
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b1;
      held <= 1'b1;
    end else begin
      meta <= din;
      held <= meta;
    end
  end

  assign dout = held;
endmodule

// File: rtl/uart_ovs_vote.sv
// Captures the first two mid-bit samples; the third is the live sample.
module uart_ovs_vote #(
  parameter int CW   = 5,
  parameter int V_LO = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          smp,
  output logic          maj,
  output logic          mixed,
  output logic          all_hi,
  output logic          any_hi
);
  logic v_first, v_second;
  logic v_first_n, v_second_n;

  always_comb begin
    v_first_n  = v_first;
    v_second_n = v_second;
    if (tick && cnt == CW'(V_LO))     v_first_n  = smp;
    if (tick && cnt == CW'(V_LO + 1)) v_second_n = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_first  <= 1'b0;
      v_second <= 1'b0;
    end else begin
      v_first  <= v_first_n;
      v_second <= v_second_n;
    end
  end

  assign all_hi = v_first & v_second & smp;
  assign any_hi = v_first | v_second | smp;
  assign maj    = (v_first & v_second) | (v_first & smp) | (v_second & smp);
  assign mixed  = any_hi & ~all_hi;
endmodule

// File: rtl/uart_ovs_ctrl.sv
// Frame sequencer: edge qualification, sample counting, bit assembly, flags.
module uart_ovs_ctrl
  import uart_ovs_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DW_MAX = 9,
  parameter int CW     = 5,
  parameter int BW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              smp,
  input  logic              nine_sel,
  input  logic              maj,
  input  logic              mixed,
  input  logic              all_hi,
  input  logic              any_hi,
  output rx_st_e            st,
  output logic [CW-1:0]     cnt,
  output logic              nine_q,
  output logic [DW_MAX-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_noise,
  output logic              rx_ferr
);
  localparam int V_HI = OVS / 2 + 2;
  localparam int E_A  = OVS / 2 - 5;
  localparam int E_B  = OVS / 2 - 3;
  localparam int E_C  = OVS / 2 - 1;

  rx_st_e              st_n;
  logic [CW-1:0]       cnt_n;
  logic [BW-1:0]       bidx, bidx_n, last_idx;
  logic [DW_MAX-1:0]   shr, shr_n, dat_n;
  logic                nacc, nacc_n;
  logic [2:0]          hist, hist_n;
  logic                nine_n, val_n, noi_n, fe_n;

  assign last_idx = nine_q ? BW'(DW_MAX - 1) : BW'(DW_MAX - 2);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    bidx_n = bidx;
    shr_n  = shr;
    nacc_n = nacc;
    hist_n = hist;
    nine_n = nine_q;
    dat_n  = rx_data;
    val_n  = 1'b0;
    noi_n  = rx_noise;
    fe_n   = rx_ferr;
    if (tick) begin
      case (st)
        RX_IDLE: begin
          hist_n = {hist[1:0], smp};
          if (!smp && hist == 3'b111) begin
            st_n   = RX_START;
            cnt_n  = CW'(1);
            bidx_n = '0;
            shr_n  = '0;
            nacc_n = 1'b0;
            nine_n = nine_sel;
            noi_n  = 1'b0;
            fe_n   = 1'b0;
          end
        end
        RX_START: begin
          if (smp && (cnt == CW'(E_A) || cnt == CW'(E_B) || cnt == CW'(E_C)))
            nacc_n = 1'b1;
          if (cnt == CW'(OVS)) begin
            st_n  = RX_DATA;
            cnt_n = CW'(1);
          end else begin
            cnt_n = cnt + CW'(1);
          end
          if (cnt == CW'(V_HI)) begin
            if (all_hi) begin
              st_n   = RX_IDLE;
              hist_n = 3'b000;
            end else if (any_hi) begin
              nacc_n = 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (cnt == CW'(V_HI)) begin
            shr_n[bidx] = maj;
            nacc_n      = nacc | mixed;
          end
          if (cnt == CW'(OVS)) begin
            cnt_n = CW'(1);
            if (bidx == last_idx) st_n = RX_STOP;
            else                  bidx_n = bidx + BW'(1);
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        default: begin
          cnt_n = cnt + CW'(1);
          if (cnt == CW'(V_HI)) begin
            st_n   = RX_IDLE;
            hist_n = 3'b000;
            val_n  = 1'b1;
            dat_n  = shr;
            noi_n  = nacc | mixed;
            fe_n   = ~maj;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      shr      <= '0;
      nacc     <= 1'b0;
      hist     <= 3'b000;
      nine_q   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_noise <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      bidx     <= bidx_n;
      shr      <= shr_n;
      nacc     <= nacc_n;
      hist     <= hist_n;
      nine_q   <= nine_n;
      rx_data  <= dat_n;
      rx_valid <= val_n;
      rx_noise <= noi_n;
      rx_ferr  <= fe_n;
    end
  end
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
  import uart_ovs_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DW_MAX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              rxd,
  input  logic              nine_sel,
  output logic [DW_MAX-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_noise,
  output logic              rx_ferr
);
  localparam int CW   = $clog2(OVS + 1);
  localparam int BW   = $clog2(DW_MAX);
  localparam int V_LO = OVS / 2;

  logic          rst_q_n;
  logic          smp;
  logic          maj, mixed, all_hi, any_hi;
  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic          nine_q;

  uart_ovs_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  uart_ovs_sync u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .din   (rxd),
    .dout  (smp)
  );

  uart_ovs_vote #(.CW(CW), .V_LO(V_LO)) u_vote (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .tick   (tick_16x),
    .cnt    (cnt),
    .smp    (smp),
    .maj    (maj),
    .mixed  (mixed),
    .all_hi (all_hi),
    .any_hi (any_hi)
  );

  uart_ovs_ctrl #(.OVS(OVS), .DW_MAX(DW_MAX), .CW(CW), .BW(BW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tick     (tick_16x),
    .smp      (smp),
    .nine_sel (nine_sel),
    .maj      (maj),
    .mixed    (mixed),
    .all_hi   (all_hi),
    .any_hi   (any_hi),
    .st       (st),
    .cnt      (cnt),
    .nine_q   (nine_q),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_noise (rx_noise),
    .rx_ferr  (rx_ferr)
  );
endmodule

// File: rtl/uart_ovs_rx_chk.sv
module uart_ovs_rx_chk
  import uart_ovs_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DW_MAX = 9,
  parameter int CW     = $clog2(OVS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_16x,
  input logic [DW_MAX-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_noise,
  input logic              rx_ferr,
  input rx_st_e            st,
  input logic [CW-1:0]     cnt,
  input logic              nine_q
);
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st != RX_IDLE) |-> (cnt >= CW'(1) && cnt <= CW'(OVS)));

  a_r2_start_from_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == RX_START) |-> ($past(tick_16x) && $past(st) == RX_IDLE));

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r9_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick_16x));

  a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rx_data, rx_noise, rx_ferr}) |-> (rx_valid || $rose(st == RX_START)));

  a_r7_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !nine_q) |-> (rx_data[DW_MAX-1] == 1'b0));

  a_r5_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && $past(st) == RX_START) |-> !rx_valid);
endmodule

bind uart_ovs_rx uart_ovs_rx_chk #(.OVS(OVS), .DW_MAX(DW_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_16x (tick_16x),
  .rx_data  (rx_data),
  .rx_valid (rx_valid),
  .rx_noise (rx_noise),
  .rx_ferr  (rx_ferr),
  .st       (st),
  .cnt      (cnt),
  .nine_q   (nine_q)
);

// File: tb/sim_uart_ovs_rx.sv
module sim_uart_ovs_rx;
  localparam int CLK_PER = 10;

  typedef struct {
    logic [8:0] d;
    logic       n;
    logic       f;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_16x;
  logic       rxd;
  logic       nine_sel;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       rx_noise;
  logic       rx_ferr;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t sb[$];
  logic [1:0] div;

  uart_ovs_rx u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_16x (tick_16x),
    .rxd      (rxd),
    .nine_sel (nine_sel),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_noise (rx_noise),
    .rx_ferr  (rx_ferr)
  );

  always #(CLK_PER / 2) clk = ~clk;

  // tick every fourth clock, changed on falling edges
  initial begin
    tick_16x = 1'b0;
    div      = 2'd0;
    forever begin
      @(negedge clk);
      div      = div + 2'd1;
      tick_16x = (div == 2'd0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rx_valid && !done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2/R5", "unexpected strobe", {7'd0, rx_data}, 16'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rx_data === e.d, e.req, "data", {7'd0, rx_data}, {7'd0, e.d});
        check(rx_noise === e.n, e.req, "noise", {15'd0, rx_noise}, {15'd0, e.n});
        check(rx_ferr === e.f, e.req, "ferr", {15'd0, rx_ferr}, {15'd0, e.f});
      end
    end
  end

  // value v is what the next sample tick sees
  task automatic put(input logic v);
    do @(posedge clk); while (!tick_16x);
    @(negedge clk);
    rxd = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b1);
  endtask

  task automatic send_frame(input logic [8:0] d, input bit nine,
                            input logic [15:0] smask, input int mbit,
                            input logic [15:0] dmask, input bit stopv,
                            input int adj, input string req);
    exp_t e;
    int   nb, len, fl;
    bit   fs, nz, bv;
    logic [8:0] ed;
    nb = nine ? 9 : 8;
    fs = (smask[10:8] == 3'b111);
    nz = smask[3] | smask[5] | smask[7] | (|smask[10:8]);
    ed = '0;
    for (int i = 0; i < nb; i++) begin
      bv = d[i];
      if (i == mbit) begin
        fl = $countones(dmask[10:8]);
        if (fl >= 2) bv = ~bv;
        if (fl == 1 || fl == 2) nz = 1'b1;
      end
      ed[i] = bv;
    end
    if (!fs) begin
      e.d = ed; e.n = nz; e.f = ~stopv; e.req = req;
      sb.push_back(e);
    end
    nine_sel = nine;
    for (int b = 0; b < nb + 2; b++) begin
      logic v, m;
      if (fs && b > 0) break;
      v   = (b == 0) ? 1'b0 : (b <= nb) ? d[b-1] : stopv;
      len = 16 + ((b % 2 == 1) ? adj : 0);
      for (int i = 0; i < len; i++) begin
        m = 1'b0;
        if (i < 16) begin
          if (b == 0) m = smask[i];
          else if (b - 1 == mbit) m = dmask[i];
        end
        put(v ^ m);
        if (b == 0 && i == 5)  // R9: flags cleared at the start edge
          check(rx_noise == 1'b0 && rx_ferr == 1'b0, "R9", "flags clear at start",
                {14'd0, rx_noise, rx_ferr}, 16'd0);
      end
    end
    idle(6);
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    rxd      = 1'b0;
    nine_sel = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(rx_valid == 1'b0 && rx_noise == 1'b0 && rx_ferr == 1'b0, "R12",
          "flags after reset", {13'd0, rx_valid, rx_noise, rx_ferr}, 16'd0);
    check(rx_data == 9'd0, "R12", "data after reset", {7'd0, rx_data}, 16'd0);

    // R2: low after only two high ticks starts nothing (monitor flags any strobe)
    for (int i = 0; i < 5; i++) put(1'b0);
    put(1'b1); put(1'b1);
    for (int i = 0; i < 20; i++) put(1'b0);
    idle(6);
    check(sb.size() == 0, "R2", "no frame from weak edge", 16'(sb.size()), 16'd0);

    // R1 R7: clean 8-bit frame
    send_frame(9'h0A5, 1'b0, 16'h0000, -1, 16'h0000, 1'b1, 0, "R1/R7");
    // R3: start sample 3 high
    send_frame(9'h03C, 1'b0, 16'h0008, -1, 16'h0000, 1'b1, 0, "R3");
    // R3: start sample 7 high
    send_frame(9'h05A, 1'b0, 16'h0080, -1, 16'h0000, 1'b1, 0, "R3");
    // R4: start sample 9 high
    send_frame(9'h081, 1'b0, 16'h0200, -1, 16'h0000, 1'b1, 0, "R4");
    // R11: ignored start positions 1,2,4,6,11..15
    send_frame(9'h00F, 1'b0, 16'hF856, -1, 16'h0000, 1'b1, 0, "R11");
    // R5: start middle fully high -> dropped
    send_frame(9'h0FF, 1'b0, 16'h0700, -1, 16'h0000, 1'b1, 0, "R5");
    check(sb.size() == 0, "R5", "false start gives no word", 16'(sb.size()), 16'd0);
    // R6: one disagreeing sample keeps value, flags noise
    send_frame(9'h000, 1'b0, 16'h0000, 2, 16'h0200, 1'b1, 0, "R6");
    // R6: two of three flipped -> majority changes bit 4
    send_frame(9'h0FF, 1'b0, 16'h0000, 4, 16'h0500, 1'b1, 0, "R6");
    // R7: 9-bit frame
    send_frame(9'h1A6, 1'b1, 16'h0000, -1, 16'h0000, 1'b1, 0, "R7");
    // R8: low stop bit
    send_frame(9'h155, 1'b1, 16'h0000, -1, 16'h0000, 1'b0, 0, "R8");
    // R9: outputs held after the strobe
    check(rx_ferr == 1'b1 && rx_data == 9'h155, "R9", "held after strobe",
          {6'd0, rx_ferr, rx_data}, {6'd0, 1'b1, 9'h155});
    // R10: slow and fast senders
    send_frame(9'h096, 1'b0, 16'h0000, -1, 16'h0000, 1'b1, 1, "R10");
    send_frame(9'h0C3, 1'b1, 16'h0000, -1, 16'h0000, 1'b1, -1, "R10");

    idle(20);
    check(sb.size() == 0, "R9", "every expected word delivered", 16'(sb.size()), 16'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule